// File: doc/BRIEF.md
# Cache Miss Cause Classifier

This block sits next to a cache and decides why each line request reaching it happened. Every accepted request is given one cause: prefetch, write-allocate, compulsory, conflict, capacity or miscellaneous. The counter for that cause is then incremented. Invalidation notices from the coherency side are counted under a separate coherency cause. A grand total counts all traffic of every kind.

Compulsory misses are found with a table of recently seen pages. Each page entry holds one "already referenced" bit for each 64-byte line in a 4 KB page. Conflict misses are estimated with a small tag-only buffer. This buffer remembers the line addresses of recent evictions. A demand miss to a line the cache only recently threw out is counted as a conflict. Any other demand miss to a line seen before is counted as capacity.

All addresses on the ports are line addresses, that is byte address divided by 64. Requests arrive on a valid/ready channel. `req_ready` is low in exactly the cycles in which an eviction notice is presented. The source must then hold the request and its fields stable until a cycle with `req_ready` high. Eviction and invalidation notices are single-cycle strobes with no back-pressure. The result of each accepted request appears one cycle later as a one-cycle strobe. The counters are read through an indexed, combinational read port.

Top module: `miss_cause_classifier`

## Requirements
- R1: After reset all eight counters read zero and `res_valid` is low.
- R2: `req_ready` equals the inverse of `evict_valid`. A request presented together with an eviction notice is not accepted and leaves no result and no count.
- R3: A request is accepted when `req_valid` and `req_ready` are both high. In the following cycle `res_valid` is high for exactly one cycle, with the cause on `res_cat`. The cause codes are: 0 compulsory, 1 capacity, 2 conflict, 3 coherency, 4 prefetch, 5 write-allocate, 6 miscellaneous. Code 7 selects the total on the read port only.
- R4: A request with `req_prefetch` set is a prefetch, whatever its other flags. Otherwise a request with `req_wralloc` set is a write-allocate.
- R5: A demand request (`req_demand` set, the other two flags clear) is compulsory if its line has never been referenced. Every accepted request marks its line as referenced. Line bits are kept per 4 KB page, with 64 lines per page: page = line address bits [25:6], line in page = bits [5:0].
- R6: The reference table holds 16 pages, direct-mapped on page-number bits [3:0] (line address bits [9:6]). A request to a page not held replaces the entry at that index. The new entry starts with every line bit clear, so lines of the displaced page count as compulsory again.
- R7: A demand request to a referenced line whose address is in the victim buffer is a conflict. Every accepted request removes its line address from the victim buffer.
- R8: Each eviction notice records its line address in the victim buffer. The buffer remembers only the 8 most recent notices, so the 9th notice makes the oldest one forgotten.
- R9: A demand request to a referenced line that is not in the victim buffer is capacity.
- R10: An accepted request with all three flags clear is miscellaneous.
- R11: Each invalidation notice increments the coherency counter and produces no result strobe. The total counter grows by one for each accepted request and one for each invalidation notice, so it can grow by two in one cycle.
- R12: `rd_data` shows, in the same cycle, the counter selected by `rd_sel` (codes as in R3). The value read includes every event accepted on earlier clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss/fill request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_line | input | 26 | Line address of the request |
| req_prefetch | input | 1 | Request is a prefetch |
| req_wralloc | input | 1 | Request is a write-allocate fill |
| req_demand | input | 1 | Request is a demand miss |
| evict_valid | input | 1 | Eviction notice strobe |
| evict_line | input | 26 | Line address being evicted |
| inval_valid | input | 1 | Coherency invalidation strobe |
| res_valid | output | 1 | Classification result strobe |
| res_cat | output | 3 | Cause code of the result |
| rd_sel | input | 3 | Counter select for the read port |
| rd_data | output | 64 | Selected counter value |

## Verification
The bench targets the ordering of the cause decision. A prefetch or write-allocate to an untouched line must not be counted as compulsory, and it must still mark the line. A design that skipped the marking would later report that line's first demand as compulsory instead of capacity. Page replacement at a shared table index must forget the old page's bits. A design that kept them would report capacity where compulsory is expected. The victim buffer is probed at its edges: the ninth eviction must push out the oldest address, a matched entry must vanish after one use, and a request stalled by an eviction must leave every counter unchanged. A cycle that carries both an invalidation and a request checks that the total grows by two rather than one.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [2:0] {
    CAT_COMPULSORY = 3'd0,
    CAT_CAPACITY   = 3'd1,
    CAT_CONFLICT   = 3'd2,
    CAT_COHERENCY  = 3'd3,
    CAT_PREFETCH   = 3'd4,
    CAT_WRALLOC    = 3'd5,
    CAT_MISC       = 3'd6,
    CAT_TOTAL      = 3'd7
  } cause_e;

  localparam int NUM_CAUSE = 7;
  localparam int SEL_W     = 3;
endpackage

// File: rtl/mcc_page_refs.sv
module mcc_page_refs #(
  parameter int LINE_W     = 26,
  parameter int LIP_W      = 6,
  parameter int PT_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              look_en,
  input  logic [LINE_W-1:0] look_line,
  output logic              first_touch
);
  localparam int LPP   = 1 << LIP_W;
  localparam int IDX_W = $clog2(PT_ENTRIES);
  localparam int TAG_W = LINE_W - LIP_W - IDX_W;

  logic [PT_ENTRIES-1:0] pg_vld;
  logic [TAG_W-1:0]      pg_tag  [PT_ENTRIES];
  logic [LPP-1:0]        pg_seen [PT_ENTRIES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [LIP_W-1:0] lidx;
  logic             tag_hit;

  assign lidx        = look_line[LIP_W-1:0];
  assign idx         = look_line[LIP_W +: IDX_W];
  assign tag         = look_line[LINE_W-1 -: TAG_W];
  assign tag_hit     = pg_vld[idx] && (pg_tag[idx] == tag);
  assign first_touch = !tag_hit || !pg_seen[idx][lidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_vld <= '0;
    end else if (look_en) begin
      pg_vld[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (look_en) begin
      if (tag_hit) begin
        pg_seen[idx][lidx] <= 1'b1;
      end else begin
        pg_tag[idx]  <= tag;
        pg_seen[idx] <= LPP'(1) << lidx;
      end
    end
  end
endmodule

// File: rtl/mcc_victim_tags.sv
module mcc_victim_tags #(
  parameter int LINE_W = 26,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [LINE_W-1:0] push_line,
  input  logic              probe_en,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vb_vld;
  logic [LINE_W-1:0] vb_line [DEPTH];
  logic [DEPTH-1:0]  match;
  logic [PTR_W-1:0]  wptr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vb_vld[g] && (vb_line[g] == probe_line);
  end

  assign probe_hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vb_vld <= '0;
      wptr   <= '0;
    end else begin
      if (probe_en) begin
        vb_vld <= vb_vld & ~match;
      end
      if (push_en) begin
        vb_vld[wptr] <= 1'b1;
        wptr         <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) begin
      vb_line[wptr] <= push_line;
    end
  end
endmodule

// File: rtl/mcc_counter_bank.sv
module mcc_counter_bank
  import mcc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] bump,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [CNT_W-1:0]     rd_data
);
  localparam int NUM_CNT = NUM_CAUSE + 1;

  logic [CNT_W-1:0] cnt [NUM_CNT];

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (bump[g]) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt[NUM_CAUSE] <= '0;
    end else begin
      cnt[NUM_CAUSE] <= cnt[NUM_CAUSE] + CNT_W'($countones(bump));
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) < NUM_CNT) begin
      rd_data = cnt[rd_sel];
    end
  end
endmodule

// File: rtl/miss_cause_classifier.sv
module miss_cause_classifier
  import mcc_pkg::*;
#(
  parameter int LINE_W     = 26,
  parameter int LIP_W      = 6,
  parameter int PT_ENTRIES = 16,
  parameter int VB_DEPTH   = 8,
  parameter int CNT_W      = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_prefetch,
  input  logic              req_wralloc,
  input  logic              req_demand,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  input  logic              inval_valid,
  output logic              res_valid,
  output logic [2:0]        res_cat,
  input  logic [2:0]        rd_sel,
  output logic [CNT_W-1:0]  rd_data
);
  logic                 accept;
  logic                 first_touch;
  logic                 vb_hit;
  cause_e               cat;
  logic [NUM_CAUSE-1:0] bump;

  // Eviction notices own the victim buffer port in their cycle.
  assign req_ready = !evict_valid;
  assign accept    = req_valid && req_ready;

  mcc_page_refs #(
    .LINE_W    (LINE_W),
    .LIP_W     (LIP_W),
    .PT_ENTRIES(PT_ENTRIES)
  ) i_refs (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_en    (accept),
    .look_line  (req_line),
    .first_touch(first_touch)
  );

  mcc_victim_tags #(
    .LINE_W(LINE_W),
    .DEPTH (VB_DEPTH)
  ) i_victims (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (evict_valid),
    .push_line (evict_line),
    .probe_en  (accept),
    .probe_line(req_line),
    .probe_hit (vb_hit)
  );

  always_comb begin
    if (req_prefetch)      cat = CAT_PREFETCH;
    else if (req_wralloc)  cat = CAT_WRALLOC;
    else if (!req_demand)  cat = CAT_MISC;
    else if (first_touch)  cat = CAT_COMPULSORY;
    else if (vb_hit)       cat = CAT_CONFLICT;
    else                   cat = CAT_CAPACITY;
  end

  always_comb begin
    bump = '0;
    if (accept)      bump[int'(cat)]           = 1'b1;
    if (inval_valid) bump[int'(CAT_COHERENCY)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_cat   <= 3'd0;
    end else begin
      res_valid <= accept;
      if (accept) res_cat <= cat;
    end
  end

  mcc_counter_bank #(
    .CNT_W(CNT_W)
  ) i_counters (
    .clk    (clk),
    .rst_n  (rst_n),
    .bump   (bump),
    .rd_sel (rd_sel),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_prefetch,
  input logic       req_wralloc,
  input logic       req_demand,
  input logic       evict_valid,
  input logic       res_valid,
  input logic [2:0] res_cat
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_EVICT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !req_ready); // R2
  AST_RESULT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid); // R3
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !res_valid); // R3
  AST_PREFETCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_prefetch) |=> (res_cat == 3'd4)); // R4
  AST_WRALLOC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_prefetch && req_wralloc) |=> (res_cat == 3'd5)); // R4
  AST_MISC_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_prefetch && !req_wralloc && !req_demand) |=> (res_cat == 3'd6)); // R10
  AST_DEMAND_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_prefetch && !req_wralloc && req_demand) |=> (res_cat <= 3'd2)); // R5
endmodule

bind miss_cause_classifier mcc_checker i_mcc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_prefetch(req_prefetch),
  .req_wralloc (req_wralloc),
  .req_demand  (req_demand),
  .evict_valid (evict_valid),
  .res_valid   (res_valid),
  .res_cat     (res_cat)
);

// File: tb/test_miss_cause_classifier.sv
`timescale 1ns/1ps
module test_miss_cause_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_line = '0;
  logic        req_prefetch = 1'b0;
  logic        req_wralloc = 1'b0;
  logic        req_demand = 1'b0;
  logic        evict_valid = 1'b0;
  logic [25:0] evict_line = '0;
  logic        inval_valid = 1'b0;
  logic        res_valid;
  logic [2:0]  res_cat;
  logic [2:0]  rd_sel = '0;
  logic [63:0] rd_data;

  always #5 clk = ~clk;

  miss_cause_classifier i_miss_cause_classifier (.*);

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string cur_tag  = "";

  // behavioural reference state
  longint unsigned m_cnt [8];
  bit              exp_rv = 0;
  int              exp_cat = 0;
  int unsigned     pt_page [int];
  bit              touched [int unsigned];
  int unsigned     vq_line [$];
  bit              vq_live [$];
  int              rot = 0;

  task automatic check(bit ok, string tag, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, cur_tag, act, exp);
    end
  endtask

  function automatic string cat_tag(int c);
    case (c)
      0: return "R5 compulsory";
      1: return "R9 capacity";
      2: return "R7 conflict";
      4: return "R4 prefetch";
      5: return "R4 wralloc";
      6: return "R10 misc";
      default: return "R3 cause";
    endcase
  endfunction

  function automatic int classify(int unsigned ln, bit pf, bit wa, bit dm);
    int unsigned pg = ln >> 6;
    int          ix = int'(pg % 16);
    bit resident = pt_page.exists(ix) && pt_page[ix] == pg;
    bit first = !resident || !touched.exists(ln);
    bit vhit = 0;
    int c;
    foreach (vq_line[k]) begin
      if (vq_live[k] && vq_line[k] == ln) begin
        vhit = 1;
        vq_live[k] = 0;
      end
    end
    if (!resident) begin
      if (pt_page.exists(ix)) begin
        int unsigned old = pt_page[ix];
        int unsigned gone [$];
        foreach (touched[t]) if ((t >> 6) == old) gone.push_back(t);
        foreach (gone[q]) touched.delete(gone[q]);
      end
      pt_page[ix] = pg;
    end
    touched[ln] = 1;
    if (pf) c = 4;
    else if (wa) c = 5;
    else if (!dm) c = 6;
    else if (first) c = 0;
    else if (vhit) c = 2;
    else c = 1;
    return c;
  endfunction

  task automatic do_checks();
    check(res_valid == exp_rv, "R3 res_valid", res_valid, exp_rv);
    if (exp_rv) check(res_cat == 3'(exp_cat), cat_tag(exp_cat), res_cat, exp_cat);
    check(rd_data == m_cnt[rd_sel], (rd_sel == 3) ? "R11 coherency count" : "R12 counter read",
          rd_data, m_cnt[rd_sel]);
  endtask

  task automatic cyc(bit rv, int unsigned rl, bit pf, bit wa, bit dm,
                     bit ev, int unsigned el, bit iv);
    bit acc;
    @(negedge clk);
    do_checks();
    req_valid = rv; req_line = 26'(rl); req_prefetch = pf; req_wralloc = wa; req_demand = dm;
    evict_valid = ev; evict_line = 26'(el); inval_valid = iv;
    rd_sel = 3'(rot); rot = (rot + 1) % 8;
    #1;
    check(req_ready == !ev, "R2 ready", req_ready, !ev);
    acc = rv && !ev;
    exp_rv = acc;
    if (acc) begin
      exp_cat = classify(rl, pf, wa, dm);
      m_cnt[exp_cat]++;
      m_cnt[7]++;
    end
    if (iv) begin m_cnt[3]++; m_cnt[7]++; end
    if (ev) begin
      vq_line.push_back(el); vq_live.push_back(1);
      if (vq_line.size() > 8) begin void'(vq_line.pop_front()); void'(vq_live.pop_front()); end
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic dem(int unsigned l);  cyc(1, l, 0, 0, 1, 0, 0, 0); endtask
  task automatic evict(int unsigned l); cyc(0, 0, 0, 0, 0, 1, l, 0); endtask

  task automatic sweep(string tag);
    @(negedge clk);
    do_checks();
    req_valid = 0; evict_valid = 0; inval_valid = 0;
    exp_rv = 0;
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #0.5;
      check(rd_data == m_cnt[s], tag, rd_data, m_cnt[s]);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cur_tag = "R1 reset";
    sweep("R1 reset counters");

    // R5 / R9 basic demand
    cur_tag = "basic";
    dem(26'h000040);            // compulsory
    dem(26'h000040);            // capacity
    dem(26'h000041);            // compulsory, neighbouring line
    // R7 conflict then removal
    cur_tag = "R7 victim";
    evict(26'h000040);
    dem(26'h000040);            // conflict
    dem(26'h000040);            // capacity: entry removed
    // R4 flags, prefetch marks the line
    cur_tag = "R4 flags";
    cyc(1, 26'h000080, 1, 1, 1, 0, 0, 0); // prefetch despite others
    dem(26'h000080);                      // capacity: line marked
    cyc(1, 26'h000081, 0, 1, 1, 0, 0, 0); // write-allocate
    cyc(1, 26'h000082, 0, 0, 0, 0, 0, 0); // R10 misc
    dem(26'h000082);                      // capacity
    // R11 invalidations
    cur_tag = "R11 inval";
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(1, 26'h000083, 0, 0, 1, 0, 0, 1); // total grows by two
    // R2 stall with eviction
    cur_tag = "R2 stall";
    cyc(1, 26'h000084, 0, 0, 1, 1, 26'h000300, 0);
    dem(26'h000084);                      // accepted now, compulsory
    sweep("R12 sweep");
    // R6 page replacement at shared index
    cur_tag = "R6 replace";
    dem(26'h000C45);                      // page 0x31, idx 1
    dem(26'h000C45);                      // capacity
    dem(26'h001045);                      // page 0x41, idx 1 replaces
    dem(26'h000C45);                      // compulsory again
    // R8 victim depth
    cur_tag = "R8 depth";
    for (int i = 0; i < 9; i++) dem(26'h002000 + i);
    for (int i = 0; i < 9; i++) evict(26'h002000 + i);
    dem(26'h002000);                      // capacity: oldest forgotten
    dem(26'h002001);                      // conflict
    dem(26'h002008);                      // conflict: newest kept
    sweep("R12 sweep");

    cur_tag = "random";
    for (int n = 0; n < 3000; n++) begin
      int unsigned pg = ($urandom % 4) + (($urandom % 2) * 16);
      int unsigned ln = (pg << 6) | ($urandom % 8);
      int unsigned el = (((($urandom % 4) + (($urandom % 2) * 16))) << 6) | ($urandom % 8);
      int f = $urandom % 8;
      cyc(($urandom % 4) != 0, ln, f == 0, f == 1, f > 2,
          ($urandom % 4) == 0, el, ($urandom % 6) == 0);
    end
    sweep("R12 final sweep");
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule